// File: doc/BRIEF.md
# Turbo-Selected Reference Code Sequencer

This block chooses a reference-voltage code for each of several regulators (four by default). Every regulator owns an 8-bit setting that holds two 4-bit codes: the upper code is used while the turbo condition is active, and the lower code is used while it is inactive. The turbo condition follows an external pin. One direction of a pin change takes effect on the next clock. The other direction takes effect only after a programmable hold-off, which is 20 ms at 100 MHz by default. A control bit decides which direction is the fast one.

The control inputs pick the mode of operation:
- **Manual mode** ignores the pin and always uses the upper code.
- **Turbo mode** follows the pin, but only while the tune enable is set.
- **Disabled** holds every regulator at the 0.80 V default code.

A per-regulator decrease option extends the range below the 4-bit table. Each output is reported two ways: as a 5-bit code and as an equivalent millivolt value, which a downstream digital-to-analog stage or a checker can consume.

Top module: `turbo_ref_seq`

## Requirements
- R1: After reset, every setting holds 8'h33, the effective turbo state is 0, and every regulator reports code 5'b00011 and 800 mV.
- R2: For a selected 4-bit code n without decrease, ref_code for that regulator is {1'b0, n} and ref_mv is 740 + 20·n (740 mV at 0, 1040 mV at 15).
- R3: In turbo mode (manual_mode = 0, tune_en = 1), setting bits [7:4] apply while the effective turbo state is 1, and bits [3:0] apply while it is 0.
- R4: With turbo_inv = 0, a 0→1 change on turbo_in sets the effective state on the first clock edge. A 1→0 change takes effect on the DELAY_CYC-th edge after the change, provided turbo_in holds steady for that whole time.
- R5: With turbo_inv = 1, the directions swap: 1→0 takes effect on the first edge, and 0→1 waits DELAY_CYC edges.
- R6: If turbo_in returns to the effective state before a delayed change completes, the pending change is dropped. A later change then waits a full DELAY_CYC edges again.
- R7: With manual_mode = 1, each regulator uses setting bits [7:4] whatever turbo_in or the effective turbo state is.
- R8: With manual_mode = 0 and tune_en = 0, every regulator reports code 5'b00011 and 800 mV, whatever its setting or dec_en.
- R9: When dec_en[i] = 1 and the selected code has bits [3:2] = 00, regulator i reports code {3'b100, n[1:0]} and 720 − 20·n[1:0] mV (0.72, 0.70, 0.68 and 0.66 V). When bits [3:2] are nonzero, dec_en has no effect.
- R10: A write with cfg_we = 1 loads cfg_data into the setting selected by cfg_sel on that clock edge. The other settings are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| turbo_in | input | 1 | Turbo request pin, synchronous to clk |
| manual_mode | input | 1 | 1 selects manual use of the upper code |
| tune_en | input | 1 | Enables pin-driven selection in turbo mode |
| turbo_inv | input | 1 | 0: rising change is immediate; 1: falling change is immediate |
| dec_en | input | NREG | Per-regulator decrease-range enable |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | SELW | Index of the setting to write |
| cfg_data | input | 8 | Setting value: [7:4] turbo-high code, [3:0] turbo-low code |
| ref_code | output | NREG*5 | 5-bit code per regulator, regulator i at [i*5 +: 5] |
| ref_mv | output | NREG*11 | Reference in millivolts per regulator, regulator i at [i*11 +: 11] |

## Verification
The assertions check the turbo tracker on every cycle. The fast direction must land on the next edge. A slow change must never land before its counter reaches the limit. The counter must return to zero whenever the pin agrees with the effective state. The assertions also check that a write lands in the selected setting, and that a manual-mode output stays still while the pin toggles. Only the bench scenarios can show the end-to-end results: the exact edge on which a delayed change appears, the restart after a cancelled change, the full millivolt table, the decrease remapping, and the disabled default.

// File: rtl/turbo_ref_seq.sv
`timescale 1ns/1ps
module turbo_ref_seq #(
  parameter int NREG      = 4,
  parameter int DELAY_CYC = 2000000,
  localparam int SELW     = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 turbo_in,
  input  logic                 manual_mode,
  input  logic                 tune_en,
  input  logic                 turbo_inv,
  input  logic [NREG-1:0]      dec_en,
  input  logic                 cfg_we,
  input  logic [SELW-1:0]      cfg_sel,
  input  logic [7:0]           cfg_data,
  output logic [NREG*5-1:0]    ref_code,
  output logic [NREG*11-1:0]   ref_mv
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  logic          turbo_eff;
  logic [CW-1:0] wait_cnt;

  wire differs = turbo_in ^ turbo_eff;
  wire fast    = differs & (turbo_in ^ turbo_inv);
  wire active  = manual_mode | tune_en;
  wire use_hi  = manual_mode | turbo_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turbo_eff <= 1'b0;
      wait_cnt  <= '0;
    end else if (!differs) begin
      wait_cnt  <= '0;
    end else if (fast || wait_cnt == LAST) begin
      turbo_eff <= turbo_in;
      wait_cnt  <= '0;
    end else begin
      wait_cnt  <= wait_cnt + 1'b1;
    end
  end

  assert_fast_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (turbo_in != turbo_eff && (turbo_in ^ turbo_inv)) |=> turbo_eff == $past(turbo_in));

  assert_slow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (turbo_in != turbo_eff && !(turbo_in ^ turbo_inv) && wait_cnt != LAST)
      |=> turbo_eff == $past(turbo_eff));

  assert_cancel_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (turbo_in == turbo_eff) |=> wait_cnt == '0);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] set_q;
    logic [3:0] nib;
    logic [4:0] code;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        set_q <= 8'h33;
      else if (cfg_we && cfg_sel == SELW'(g))
        set_q <= cfg_data;
    end

    assign nib  = !active ? 4'd3 : (use_hi ? set_q[7:4] : set_q[3:0]);
    assign code = (active && dec_en[g] && nib[3:2] == 2'b00) ? {3'b100, nib[1:0]}
                                                             : {1'b0, nib};

    assign ref_code[g*5 +: 5] = code;
    assign ref_mv[g*11 +: 11] = code[4] ? (11'd720 - 11'(code[1:0]) * 11'd20)
                                        : (11'd740 + 11'(code[3:0]) * 11'd20);

    assert_cfg_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == SELW'(g)) |=> set_q == $past(cfg_data));

    assert_manual_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (manual_mode && $past(manual_mode) && $stable(set_q) && $stable(dec_en))
        |-> $stable(code));
  end
endmodule

// File: tb/sim_turbo_ref_seq.sv
`timescale 1ns/1ps
module sim_turbo_ref_seq;
  localparam int N = 4;
  localparam int D = 40;

  logic clk = 0, rst_n = 0, turbo_in = 0, manual_mode = 0, tune_en = 1, turbo_inv = 0;
  logic [N-1:0] dec_en = '0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [7:0] cfg_data = 0;
  logic [N*5-1:0] ref_code;
  logic [N*11-1:0] ref_mv;

  int checks = 0, failures = 0;
  logic [7:0] s [N];
  bit exp_t = 0;

  always #5 clk = ~clk;

  turbo_ref_seq #(.NREG(N), .DELAY_CYC(D)) u0 (
    .clk(clk), .rst_n(rst_n), .turbo_in(turbo_in), .manual_mode(manual_mode),
    .tune_en(tune_en), .turbo_inv(turbo_inv), .dec_en(dec_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .ref_code(ref_code), .ref_mv(ref_mv));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_reg(string req, int i);
    int nib, c, mv;
    bit off = !(manual_mode || tune_en);
    nib = off ? 3 : ((manual_mode || exp_t) ? int'(s[i][7:4]) : int'(s[i][3:0]));
    if (!off && dec_en[i] && nib < 4) begin c = 16 + nib; mv = 720 - 20*nib; end
    else begin c = nib; mv = 740 + 20*nib; end
    chk({req, " code"}, int'(ref_code[i*5 +: 5]), c);
    chk({req, " mv"}, int'(ref_mv[i*11 +: 11]), mv);
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < N; i++) check_reg(req, i);
  endtask

  task automatic wr(int i, logic [7:0] d);
    cfg_we = 1; cfg_sel = 2'(i); cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
    s[i] = d;
  endtask

  task automatic t_reset;
    check_all("R1 reset");
  endtask

  task automatic t_map;
    for (int n = 0; n < 16; n++) begin
      wr(n % N, {4'h3, 4'(n)});
      chk("R2 code", int'(ref_code[(n % N)*5 +: 5]), n);
      chk("R2 mv", int'(ref_mv[(n % N)*11 +: 11]), 740 + 20*n);
    end
  endtask

  task automatic t_write;
    wr(0, 8'hA5); wr(1, 8'h6C); wr(2, 8'hF0); wr(3, 8'h49);
    wr(2, 8'h1E);
    check_all("R10 write isolation");
  endtask

  task automatic t_inv0;
    turbo_inv = 0; turbo_in = 1;
    @(negedge clk); exp_t = 1;
    check_all("R3/R4 rise immediate");
    turbo_in = 0;
    repeat (D-1) @(negedge clk);
    check_all("R4 fall still pending");
    @(negedge clk); exp_t = 0;
    check_all("R4 fall after delay");
  endtask

  task automatic t_inv1;
    turbo_inv = 1; turbo_in = 1;
    repeat (D-1) @(negedge clk);
    check_all("R5 rise still pending");
    @(negedge clk); exp_t = 1;
    check_all("R5 rise after delay");
    turbo_in = 0;
    @(negedge clk); exp_t = 0;
    check_all("R5 fall immediate");
    turbo_inv = 0;
  endtask

  task automatic t_cancel;
    turbo_in = 1;
    @(negedge clk); exp_t = 1;
    turbo_in = 0;
    repeat (20) @(negedge clk);
    turbo_in = 1;
    @(negedge clk);
    check_all("R6 reversal keeps state");
    turbo_in = 0;
    repeat (D-1) @(negedge clk);
    check_all("R6 restarted delay pending");
    @(negedge clk); exp_t = 0;
    check_all("R6 restarted delay done");
  endtask

  task automatic t_manual;
    manual_mode = 1;
    @(negedge clk);
    check_all("R7 manual eff0");
    turbo_in = 1;
    @(negedge clk); exp_t = 1;
    check_all("R7 manual eff1");
    turbo_in = 0;
    repeat (D) @(negedge clk); exp_t = 0;
    check_all("R7 manual after fall");
    manual_mode = 0;
  endtask

  task automatic t_decrease;
    dec_en = 4'b0111;
    wr(0, 8'h30); wr(1, 8'h31); wr(2, 8'h43); wr(3, 8'h52);
    check_all("R9 decrease range");
    chk("R9 0.66V", int'(ref_mv[2*11 +: 11]), 660);
    wr(0, 8'h34);
    check_reg("R9 no effect above 3", 0);
  endtask

  task automatic t_disabled;
    tune_en = 0;
    wr(1, 8'hFE);
    check_all("R8 disabled default");
    turbo_in = 1;
    @(negedge clk); exp_t = 1;
    check_all("R8 disabled turbo high");
    tune_en = 1;
    @(negedge clk);
    check_all("R8 re-enabled");
  endtask

  initial begin
    for (int i = 0; i < N; i++) s[i] = 8'h33;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_map();
    t_write();
    t_inv0();
    t_inv1();
    t_cancel();
    t_manual();
    t_decrease();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule